// File: doc/BRIEF.md
# DRAM Strobe Sequencer

This block produces the repeating control strobes that a multiplexed-address DRAM needs: a row strobe, a row/column address-select, a column strobe and a late strobe that marks the end of the access. It also produces a processor phase clock at one fourteenth of the master clock rate. All five outputs are active-low in the strobe sense (high means idle) and each one comes straight from a flip-flop.

The strobes are not decoded from a counter. They form a self-sustaining ring: the next value of each strobe is a fixed logic function of the present strobe values, so the four bits step through seven states and return to the start. A mode input picks between two column-strobe equations. In safe mode the column strobe stays low one extra clock. In early mode it is a one-clock delay of the address-select and rises together with the row strobe. A RAM-select input holds the column strobe output high without disturbing the ring, so an access cycle can be suppressed when the memory is not addressed.

Top module: `dram_strobe_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `ras_o`=1, `ax_o`=1, `cas_o`=1, `q3_o`=1, `phi0_o`=1.
- R2: With `early_cas`=0 and `ram_sel`=1, the outputs (`ras_o`,`ax_o`,`cas_o`,`q3_o`) in the clocks after reset are 0111, 0011, 0001, 0000, 0100, 1100, 1111. The sequence then repeats with period 7.
- R3: With `early_cas`=1 and `ram_sel`=1, the sequence is the same as in R2, except that the state following 0100 is 1110 and not 1100.
- R4: `ras_o` rises once every 7 clocks. It stays high for exactly 2 consecutive clocks and then low for 5.
- R5: Falling order: `ax_o` falls one clock after `ras_o` falls, the internal column strobe one clock after `ax_o`, and `q3_o` one clock after the column strobe.
- R6: Rising order: `ax_o` rises one clock after `q3_o` falls, and `ras_o` rises one clock after `ax_o` rises.
- R7: `phi0_o` inverts at each edge where the present state has `ras_o`=1 and `q3_o`=0, and at no other edge. It is high for 7 clocks and low for 7 clocks.
- R8: If `ram_sel` is 0 at a rising edge, `cas_o` is 1 after that edge. `ras_o`, `ax_o`, `q3_o` and `phi0_o` follow the same sequence they would follow with `ram_sel`=1.
- R9: `early_cas` is sampled at every edge. A change takes effect at the next edge, and it only alters `cas_o` in the state that follows 0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| ram_sel | input | 1 | 1 lets the column strobe reach `cas_o`; 0 holds `cas_o` high |
| early_cas | input | 1 | 0 = safe column release, 1 = early column release |
| ras_o | output | 1 | Row address strobe |
| ax_o | output | 1 | Address select: 1 = row address, 0 = column address |
| cas_o | output | 1 | Column address strobe, gated by `ram_sel` |
| q3_o | output | 1 | Late strobe that ends the access slot |
| phi0_o | output | 1 | Processor phase clock, master clock divided by 14 |

## Verification
The following are checked by assertions on every cycle: the falling and rising order of the strobes, the two-clock width of the row strobe, the rule that the phase clock toggles only in the row-high/late-low state, and the forced-high column strobe output while `ram_sel` is low. Some properties need the whole ring to be walked and compared against an independent model, so only the bench scenarios can show them. These are the exact tuple order in each release mode, the 7-clock and 14-clock periods over many cycles, a mode change in the middle of a cycle, and the recovery from a second reset.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef struct packed {
        logic ras;
        logic ax;
        logic cas;
        logic q3;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras: 1'b1, ax: 1'b1, cas: 1'b1, q3: 1'b1};

    typedef enum logic {
        CAS_SAFE  = 1'b0,
        CAS_EARLY = 1'b1
    } cas_mode_e;

endpackage

// File: rtl/strobe_ring.sv
module strobe_ring
    import dram_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    early_cas,
    output strobe_t state_o,
    output strobe_t next_o
);

    strobe_t   ring_d, ring_q;
    cas_mode_e mode;

    assign mode = cas_mode_e'(early_cas);

    always_comb begin
        ring_d     = ring_q;
        ring_d.ras = ring_q.ax & ~ring_q.q3;
        ring_d.ax  = ring_q.ras | ~ring_q.q3;
        ring_d.q3  = ring_q.ras | ring_q.cas;
        if (mode == CAS_EARLY)
            ring_d.cas = ring_q.ax;
        else
            ring_d.cas = (ring_q.ax & ring_q.q3) | ring_q.ras;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ring_q <= STROBE_IDLE;
        else
            ring_q <= ring_d;
    end

    assign state_o = ring_q;
    assign next_o  = ring_d;

    // R5: strobe falling order
    assert_ax_after_ras_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ring_q.ras) |=> $fell(ring_q.ax));
    assert_cas_after_ax_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ring_q.ax) |=> $fell(ring_q.cas));
    assert_q3_after_cas_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ring_q.cas) |=> $fell(ring_q.q3));
    // R6: strobe rising order
    assert_ax_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ring_q.q3) |=> $rose(ring_q.ax));
    assert_ras_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ring_q.ax) |=> $rose(ring_q.ras));
    // R4: row strobe is high for two clocks at most
    assert_ras_width_R4: assert property (@(posedge clk) disable iff (rst)
        (ring_q.ras && $past(ring_q.ras)) |=> !ring_q.ras);

endmodule

// File: rtl/phase_divider.sv
module phase_divider (
    input  logic clk,
    input  logic rst,
    input  logic ras,
    input  logic q3,
    output logic phi0_o
);

    logic phi_d, phi_q;
    logic wrap;

    assign wrap = ras & ~q3;

    always_comb begin
        phi_d = phi_q;
        if (wrap)
            phi_d = ~phi_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            phi_q <= 1'b1;
        else
            phi_q <= phi_d;
    end

    assign phi0_o = phi_q;

    // R7: phase flips only in the row-high, late-low state
    assert_phase_flip_R7: assert property (@(posedge clk) disable iff (rst)
        (ras && !q3) |=> (phi_q != $past(phi_q)));
    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(ras && !q3) |=> $stable(phi_q));

endmodule

// File: rtl/cas_gate.sv
module cas_gate (
    input  logic clk,
    input  logic rst,
    input  logic ram_sel,
    input  logic cas_next,
    output logic cas_o
);

    logic pin_d, pin_q;

    always_comb begin
        pin_d = cas_next;
        if (!ram_sel)
            pin_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pin_q <= 1'b1;
        else
            pin_q <= pin_d;
    end

    assign cas_o = pin_q;

    // R8: deselected RAM keeps the column strobe output idle
    assert_cas_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !ram_sel |=> cas_o);

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
    import dram_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ram_sel,
    input  logic early_cas,
    output logic ras_o,
    output logic ax_o,
    output logic cas_o,
    output logic q3_o,
    output logic phi0_o
);

    strobe_t state, next;

    strobe_ring ring_i (
        .clk      (clk),
        .rst      (rst),
        .early_cas(early_cas),
        .state_o  (state),
        .next_o   (next)
    );

    phase_divider phase_i (
        .clk   (clk),
        .rst   (rst),
        .ras   (state.ras),
        .q3    (state.q3),
        .phi0_o(phi0_o)
    );

    cas_gate gate_i (
        .clk     (clk),
        .rst     (rst),
        .ram_sel (ram_sel),
        .cas_next(next.cas),
        .cas_o   (cas_o)
    );

    assign ras_o = state.ras;
    assign ax_o  = state.ax;
    assign q3_o  = state.q3;

    // R1: reset leaves every output idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (ras_o && ax_o && cas_o && q3_o && phi0_o));

endmodule

// File: tb/dram_strobe_seq_tb.sv
module dram_strobe_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ram_sel = 1'b1;
    logic early_cas = 1'b0;
    logic ras_o, ax_o, cas_o, q3_o, phi0_o;

    typedef struct {
        logic [4:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int model_slot = 0;
    logic model_phi = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_strobe_seq dut_i (
        .clk      (clk),
        .rst      (rst),
        .ram_sel  (ram_sel),
        .early_cas(early_cas),
        .ras_o    (ras_o),
        .ax_o     (ax_o),
        .cas_o    (cas_o),
        .q3_o     (q3_o),
        .phi0_o   (phi0_o)
    );

    // Tuple order (ras,ax,cas,q3) per slot, slot 0 = idle state
    function automatic logic [3:0] slot_tuple(int s, logic early);
        case (s)
            0: slot_tuple = 4'b1111;
            1: slot_tuple = 4'b0111;
            2: slot_tuple = 4'b0011;
            3: slot_tuple = 4'b0001;
            4: slot_tuple = 4'b0000;
            5: slot_tuple = 4'b0100;
            default: slot_tuple = early ? 4'b1110 : 4'b1100;
        endcase
    endfunction

    // Driver: apply inputs for the next edge and push the expected result
    task automatic step(input logic r, input logic sel, input logic early, input string req);
        item_t it;
        logic [3:0] t;
        @(negedge clk);
        rst = r;
        ram_sel = sel;
        early_cas = early;
        if (r) begin
            model_slot = 0;
            model_phi = 1'b1;
            it.exp = 5'b11111;
        end else begin
            if (model_slot == 6) model_phi = ~model_phi;
            model_slot = (model_slot + 1) % 7;
            t = slot_tuple(model_slot, early);
            it.exp = {t[3], t[2], t[1] | ~sel, t[0], model_phi};
        end
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: sample a quarter period after each edge
    initial begin
        item_t it;
        int cyc = 0;
        int last_rise = -1;
        int last_phi = -1;
        logic prev_ras = 1'b1;
        logic prev_phi = 1'b1;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            cyc++;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check({ras_o, ax_o, cas_o, q3_o, phi0_o} == it.exp, it.req,
                      int'({ras_o, ax_o, cas_o, q3_o, phi0_o}), int'(it.exp));
            end
            if (rst) begin
                last_rise = -1;
                last_phi = -1;
            end else begin
                if (ras_o && !prev_ras) begin
                    if (last_rise >= 0) check(cyc - last_rise == 7, "R4 ras period", cyc - last_rise, 7);
                    last_rise = cyc;
                end
                if (phi0_o != prev_phi) begin
                    if (last_phi >= 0) check(cyc - last_phi == 7, "R7 phase half period", cyc - last_phi, 7);
                    last_phi = cyc;
                end
            end
            prev_ras = ras_o;
            prev_phi = phi0_o;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R1 reset");
        // R2 safe sequence, R5 R6 ordering
        for (int i = 0; i < 28; i++) step(1'b0, 1'b1, 1'b0, "R2 R5 R6 safe");
        // R3 early sequence
        for (int i = 0; i < 28; i++) step(1'b0, 1'b1, 1'b1, "R3 early");
        // R9 mode changes at varying points of the ring
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, ((i / 3) % 2) == 1, "R9 mode switch");
        // R8 deselected RAM, ring keeps running
        for (int i = 0; i < 21; i++) step(1'b0, 1'b0, 1'b0, "R8 cas held");
        for (int i = 0; i < 21; i++) step(1'b0, (i % 4) != 0, 1'b1, "R8 ram_sel toggling");
        // R1 second reset mid-cycle
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, "R2 pre-reset");
        for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 1'b1, "R1 re-reset");
        // R7 long run for phase period
        for (int i = 0; i < 210; i++) step(1'b0, 1'b1, 1'b0, "R7 R4 long run");
        @(posedge clk);
        #(CLK_PERIOD/2);
        finish_run();
    end

endmodule